// File: doc/BRIEF.md
# Two-wire register-write control port

This block is a slave-only two-wire serial control port. Its job is to load 16-bit values into an on-chip register file of 256 entries. A bus master opens a transfer with a start condition and sends a device byte. That byte holds a 7-bit identifier and a direction bit. The master then sends one byte that selects a register and two bytes that carry its new value, high byte first. The port acknowledges every byte it accepts by pulling the data line low for the ninth clock. Open-drain behaviour is modelled as an output enable. When the port sees the last acknowledge of a frame, it issues a single write to the register file and shows that write on a one-cycle strobe.

The port only accepts writes. A device byte that asks for a read is refused in the same way as a wrong identifier. A strap input chooses the identifier: the port captures it in the final cycle of reset and ignores it afterwards. The serial lines are brought into a faster internal clock through synchronizers, and every protocol event comes from their sampled edges. One bit of register 22 enables the system clock. While that bit is set and the master clock is reported absent, writes to every register except register 22 are dropped.

Top module: `ctl_port_wr`

## Requirements
- R1: A frame after an accepted device byte is three bytes, MSB first: the register address, then data bits 15:8, then data bits 7:0. The register file then holds the data at that address, and rd_data returns it one clock after rd_addr is applied.
- R2: With addr_strap low in the last reset cycle, the identifier is 7'b0011010. A device byte equal to {identifier, 0} is acknowledged by sda_oe=1 for the whole ninth SCL high phase. No other value of the 7 identifier bits is acknowledged.
- R3: With addr_strap high in the last reset cycle, the identifier is 7'b0011011. Changes on addr_strap after reset leave the identifier unchanged.
- R4: A device byte with a wrong identifier, or with the direction bit (bit 0) at 1, gets no acknowledge. Bytes that follow it get no acknowledge and cause no write until the next start condition.
- R5: The register byte and both data bytes of an accepted frame are each acknowledged. sda_oe asserts only while the synchronized SCL is low.
- R6: Each completed frame gives exactly one wr_stb pulse, one clock wide, carrying that frame's address on wr_addr and its data on wr_data. No strobe appears without a completed frame.
- R7: Bit 0 of register 22 is the clock-enable bit. While it is 1 and mclk_present is 0, a completed frame to any address other than 22 is still acknowledged, but it gives no strobe and leaves the register unchanged. Writes to register 22 always take effect.
- R8: A stop condition (SDA rising while SCL is high) or a repeated start (SDA falling while SCL is high) before the third data acknowledge discards the partial frame without a write. After a repeated start, the next byte is treated as a new device byte.
- R9: Reset holds sda_oe at 0 and wr_stb at 0 and clears the clock-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high power-on reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level as seen on the bus |
| addr_strap | input | 1 | Identifier select strap, captured during reset |
| mclk_present | input | 1 | High when the master clock is running |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| wr_stb | output | 1 | One-cycle strobe for a write that took effect |
| wr_addr | output | 8 | Register address of the strobed write |
| wr_data | output | 16 | Data of the strobed write |
| rd_addr | input | 8 | Register file read address |
| rd_data | output | 16 | Registered read data, one cycle after rd_addr |

## Verification
The assertions check the following on every cycle: the identifier stays fixed once reset ends; the acknowledge drive rises only after the synchronized clock has gone low; every strobe comes from a completed frame and lasts one cycle; and no strobed write broke the clock-gating rule. Other behaviours can only be shown by the bench's scenarios. These are: which identifiers are acknowledged under each strap setting; the full sweep of all 128 identifiers; refused reads; frames cut short by stop or by repeated start; and gated writes. For each of these, the bench shows whether the register file contents seen at the read port and the acknowledge pattern on the bus match the values it computes.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_BITS    = 2'd1,
    ST_ACKWAIT = 2'd2,
    ST_ACK     = 2'd3
  } rx_state_t;
endpackage

// File: rtl/ctlp_sync.sv
// Multi-stage synchronizer per line plus a one-cycle delayed copy used for
// edge detection. Lines reset high (idle bus level).
module ctlp_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] prv
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain    <= '1;
        prv[g]   <= 1'b1;
      end else begin
        chain    <= {chain[STAGES-2:0], raw[g]};
        prv[g]   <= chain[STAGES-1];
      end
    end
    assign lvl[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/ctlp_rx.sv
// Protocol engine: device byte match, register byte, data bytes, acks.
module ctlp_rx
  import ctlp_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl,
  input  logic          scl_p,
  input  logic          sda,
  input  logic          sda_p,
  input  logic [6:0]    dev_id,
  output logic          sda_oe,
  output logic          req,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data
);
  localparam int NBYTES = 1 + DW / 8;           // bytes after the device byte
  localparam int IW     = $clog2(NBYTES + 1);
  localparam logic [IW-1:0] LAST = IW'(NBYTES);

  rx_state_t       state;
  logic [2:0]      bit_cnt;
  logic [IW-1:0]   idx;
  logic [6:0]      sh;
  logic [AW-1:0]   addr_r;
  logic [DW-1:0]   data_r;
  logic [7:0]      nb;
  logic            start_ev, stop_ev, rise, fall;

  assign start_ev = scl & scl_p & sda_p & ~sda;
  assign stop_ev  = scl & scl_p & ~sda_p & sda;
  assign rise     = scl & ~scl_p;
  assign fall     = ~scl & scl_p;
  assign nb       = {sh, sda};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      idx      <= '0;
      sh       <= '0;
      addr_r   <= '0;
      data_r   <= '0;
      sda_oe   <= 1'b0;
      req      <= 1'b0;
      req_addr <= '0;
      req_data <= '0;
    end else begin
      req <= 1'b0;
      if (start_ev) begin
        state   <= ST_BITS;
        bit_cnt <= '0;
        idx     <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_ev) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_BITS: if (rise) begin
            sh      <= nb[6:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              if (idx == '0) begin
                if (nb[7:1] == dev_id && !nb[0]) state <= ST_ACKWAIT;
                else                             state <= ST_IDLE;
              end else if (idx == IW'(1)) begin
                addr_r <= nb[AW-1:0];
                state  <= ST_ACKWAIT;
              end else begin
                data_r <= {data_r[DW-9:0], nb};
                state  <= ST_ACKWAIT;
              end
            end
          end
          ST_ACKWAIT: if (fall) begin
            sda_oe <= 1'b1;
            state  <= ST_ACK;
          end
          ST_ACK: if (fall) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            if (idx == LAST) begin
              req      <= 1'b1;
              req_addr <= addr_r;
              req_data <= data_r;
              state    <= ST_IDLE;
            end else begin
              idx   <= idx + IW'(1);
              state <= ST_BITS;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctlp_regfile.sv
// Single write port, registered read port; no reset so block RAM can be used.
module ctlp_regfile #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ctl_port_wr.sv
module ctl_port_wr #(
  parameter int         AW          = 8,
  parameter int         DW          = 16,
  parameter int         CLK_REG     = 22,
  parameter int         CLKEN_BIT   = 0,
  parameter logic [6:0] ID_BASE     = 7'b0011010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          addr_strap,
  input  logic          mclk_present,
  output logic          sda_oe,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam logic [AW-1:0] CLK_REG_A = AW'(CLK_REG);

  logic [1:0]    lvl, prv;
  logic          scl_s;
  logic          id_lsb;
  logic [6:0]    dev_id;
  logic          req;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          clk_en_q;
  logic          allow, we;

  ctlp_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .raw ({sda_in, scl_in}),
    .lvl (lvl),
    .prv (prv)
  );
  assign scl_s = lvl[0];

  // Strap sampled on every reset cycle; the last one before release wins.
  always_ff @(posedge clk) begin
    if (rst) id_lsb <= addr_strap;
  end
  assign dev_id = ID_BASE | {6'd0, id_lsb};

  ctlp_rx #(.AW(AW), .DW(DW)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .scl      (lvl[0]),
    .scl_p    (prv[0]),
    .sda      (lvl[1]),
    .sda_p    (prv[1]),
    .dev_id   (dev_id),
    .sda_oe   (sda_oe),
    .req      (req),
    .req_addr (req_addr),
    .req_data (req_data)
  );

  assign allow = ~clk_en_q | mclk_present | (req_addr == CLK_REG_A);
  assign we    = req & allow;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_en_q <= 1'b0;
      wr_stb   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_stb <= we;
      if (we) begin
        wr_addr <= req_addr;
        wr_data <= req_data;
        if (req_addr == CLK_REG_A) clk_en_q <= req_data[CLKEN_BIT];
      end
    end
  end

  ctlp_regfile #(.AW(AW), .DW(DW)) u_rf (
    .clk   (clk),
    .we    (we),
    .waddr (req_addr),
    .wdata (req_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/ctlp_chk.sv
module ctlp_chk #(
  parameter int AW      = 8,
  parameter int CLK_REG = 22
) (
  input logic          clk,
  input logic          rst,
  input logic          sda_oe,
  input logic          wr_stb,
  input logic [AW-1:0] wr_addr,
  input logic          mclk_present,
  input logic          clk_en,
  input logic          scl_s,
  input logic [6:0]    dev_id,
  input logic          req
);
  assert_id_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(dev_id));

  assert_ack_on_low_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_s));

  assert_stb_from_frame_R6: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(req));

  assert_stb_single_R6: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  assert_gate_rule_R7: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> ($past(mclk_present) || !$past(clk_en) || wr_addr == AW'(CLK_REG)));
endmodule

bind ctl_port_wr ctlp_chk #(.AW(AW), .CLK_REG(CLK_REG)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sda_oe       (sda_oe),
  .wr_stb       (wr_stb),
  .wr_addr      (wr_addr),
  .mclk_present (mclk_present),
  .clk_en       (clk_en_q),
  .scl_s        (scl_s),
  .dev_id       (dev_id),
  .req          (req)
);

// File: tb/ctl_port_wr_tb.sv
`timescale 1ns/1ps
module ctl_port_wr_tb_top;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        m_scl = 1'b1, m_sda = 1'b1;
  logic        addr_strap = 1'b0, mclk_present = 1'b1;
  logic        sda_oe, wr_stb;
  logic [7:0]  wr_addr, rd_addr = 8'd0;
  logic [15:0] wr_data, rd_data;
  logic        sda_bus;

  int checks = 0, errors = 0, stb_cnt = 0;
  logic [7:0]  last_addr;
  logic [15:0] last_data;

  always #2.5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  ctl_port_wr dut_i (
    .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_bus),
    .addr_strap(addr_strap), .mclk_present(mclk_present),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(negedge clk) if (!rst && wr_stb) begin
    stb_cnt++;
    last_addr = wr_addr;
    last_data = wr_data;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; tq(); m_scl = 1'b1; tq(); m_sda = 1'b0; tq(); m_scl = 1'b0; tq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tq(); m_scl = 1'b1; tq(); m_sda = 1'b1; tq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ackd);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tq(); m_scl = 1'b1; tq(); tq(); m_scl = 1'b0; tq();
    end
    m_sda = 1'b1; tq(); m_scl = 1'b1; tq();
    ackd = (sda_bus == 1'b0);
    tq(); m_scl = 1'b0; tq();
  endtask

  task automatic write_frame(input logic [6:0] id, input logic [7:0] a,
                             input logic [15:0] d, output int acks);
    bit k;
    acks = 0;
    bus_start();
    send_byte({id, 1'b0}, k); acks += int'(k);
    send_byte(a, k);          acks += int'(k);
    send_byte(d[15:8], k);    acks += int'(k);
    send_byte(d[7:0], k);     acks += int'(k);
    bus_stop();
    tq();
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); rd_addr = a;
    repeat (2) @(negedge clk);
    d = rd_data;
  endtask

  task automatic do_reset(input logic strap);
    rst = 1'b1; addr_strap = strap;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    addr_strap = ~strap;
  endtask

  // Full write with checks on acks, strobe and readback.
  task automatic good_write(input logic [6:0] id, input logic [7:0] a,
                            input logic [15:0] d, input string tag);
    int acks, s0;
    logic [15:0] r;
    s0 = stb_cnt;
    write_frame(id, a, d, acks);
    chk(acks == 4, {tag, " R5 acks"}, acks, 4);
    chk(stb_cnt == s0 + 1, {tag, " R6 strobe count"}, stb_cnt - s0, 1);
    chk(last_addr == a && last_data == d, {tag, " R6 strobe addr/data"},
        {last_addr, last_data}, {a, d});
    rd(a, r);
    chk(r == d, {tag, " R1 readback"}, r, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit k;
    int acks, s0;
    logic [15:0] r;
    logic [7:0] ta [4] = '{8'h00, 8'hFF, 8'h07, 8'h80};
    logic [15:0] td [4] = '{16'h1234, 16'hA5C3, 16'h00FF, 16'hFFFF};

    rst = 1'b1; addr_strap = 1'b0;
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0 && wr_stb == 1'b0, "R9 outputs in reset", {sda_oe, wr_stb}, 0);
    do_reset(1'b0);
    chk(sda_oe == 1'b0 && wr_stb == 1'b0, "R9 outputs after reset", {sda_oe, wr_stb}, 0);

    // R2/R4: sweep every identifier with the write direction bit.
    s0 = stb_cnt;
    for (int id = 0; id < 128; id++) begin
      bus_start();
      send_byte({7'(id), 1'b0}, k);
      bus_stop();
      chk(k == (id == 7'h1A), $sformatf("R2 id sweep %0h", id), k, id == 7'h1A);
    end
    chk(stb_cnt == s0, "R4 no strobe in sweep", stb_cnt - s0, 0);

    // R4: read direction refused.
    bus_start(); send_byte({7'h1A, 1'b1}, k); bus_stop();
    chk(!k, "R4 read bit refused", k, 0);

    // R4: after a refused device byte, nothing is acknowledged or written.
    s0 = stb_cnt;
    write_frame(7'h18, 8'h07, 16'h4242, acks);
    chk(acks == 0, "R4 no acks after mismatch", acks, 0);
    chk(stb_cnt == s0, "R4 no write after mismatch", stb_cnt - s0, 0);

    // R1/R5/R6: writes with several patterns.
    for (int i = 0; i < 4; i++) good_write(7'h1A, ta[i], td[i], "R1 pattern");

    // R8: stop after the first data byte.
    s0 = stb_cnt;
    bus_start();
    send_byte({7'h1A, 1'b0}, k); send_byte(8'h07, k); send_byte(8'h55, k);
    bus_stop(); tq();
    chk(stb_cnt == s0, "R8 stop abort no strobe", stb_cnt - s0, 0);
    rd(8'h07, r);
    chk(r == 16'h00FF, "R8 stop abort reg kept", r, 16'h00FF);

    // R8: repeated start mid-frame, then a full new frame.
    s0 = stb_cnt;
    bus_start();
    send_byte({7'h1A, 1'b0}, k); send_byte(8'h07, k); send_byte(8'h66, k);
    bus_start();
    send_byte({7'h1A, 1'b0}, k);
    chk(k, "R8 device byte after repeated start acked", k, 1);
    send_byte(8'h09, k); send_byte(8'h13, k); send_byte(8'h57, k);
    bus_stop(); tq();
    chk(stb_cnt == s0 + 1 && last_addr == 8'h09, "R8 only new frame written",
        {stb_cnt - s0, last_addr}, {32'd1, 8'h09});
    rd(8'h07, r);
    chk(r == 16'h00FF, "R8 repeated start reg kept", r, 16'h00FF);
    rd(8'h09, r);
    chk(r == 16'h1357, "R8 new frame data", r, 16'h1357);

    // R7: clock gating.
    mclk_present = 1'b1;
    good_write(7'h1A, 8'd22, 16'h0001, "R7 set enable");
    mclk_present = 1'b0;
    s0 = stb_cnt;
    write_frame(7'h1A, 8'h07, 16'hBEEF, acks);
    chk(acks == 4, "R7 gated frame still acked", acks, 4);
    chk(stb_cnt == s0, "R7 gated no strobe", stb_cnt - s0, 0);
    rd(8'h07, r);
    chk(r == 16'h00FF, "R7 gated reg kept", r, 16'h00FF);
    good_write(7'h1A, 8'd22, 16'h0000, "R7 exempt reg");
    good_write(7'h1A, 8'h07, 16'hBEEF, "R7 enable clear");
    good_write(7'h1A, 8'd22, 16'h0001, "R7 set again");
    mclk_present = 1'b1;
    good_write(7'h1A, 8'h07, 16'hCAFE, "R7 clock present");

    // R9/R3: reset with enable set; strap high.
    do_reset(1'b1);
    mclk_present = 1'b0;
    good_write(7'h1B, 8'h07, 16'h0F0F, "R9 enable cleared, R3 strap id");
    bus_start(); send_byte({7'h1A, 1'b0}, k); bus_stop();
    chk(!k, "R3 base id refused with strap", k, 0);
    addr_strap = 1'b1; tq(); addr_strap = 1'b0; tq();
    bus_start(); send_byte({7'h1B, 1'b0}, k); bus_stop();
    chk(k, "R3 strap change ignored", k, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule